// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block gives a processor a set of 8-bit general-purpose I/O ports on a simple synchronous register bus. Every pin has a direction bit, an output latch and, on ports built to allow it, an open-drain drive mode. For each pin the block produces an output value and an output enable, and it takes a pad level that passes through a two-flop synchronizer before software can read it.

A read of a port's data register returns a mix. Pins set as outputs return their latch and pins set as inputs return the synchronized pad. A control bit changes what two data addresses return. While it is set, a read of 0x10 or 0x11 gives a raw-pin view of fixed bit fields of two other ports, whatever their direction bits are. Writes to these two addresses are not affected by the control bit.

Address map: the data register of port k sits at 2k and its direction register at 2k+1. The open-drain enables are at 0x2E, with bit k for port k. The control register is at 0x2F, with the remap bit in bit 0. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every direction bit, output latch, open-drain enable and the remap bit is 0. All output enables are low, and reads of the direction, open-drain and control registers return 0.
- R2: A pin whose direction bit is 1 and whose port is not in open-drain mode has its output enable high and its output value equal to its latch.
- R3: A pin whose direction bit is 0 has its output enable low.
- R4: A write to the data register of a port with input pins changes only the latches of those pins. Their output enables stay low, and the written value appears on the outputs once the direction bits are set to 1.
- R5: A read of port k's data register (address 2k) returns the latch for each bit whose direction bit is 1 and the synchronized pad level for each bit whose direction bit is 0.
- R6: With control bit 0 at 0x2F set, a read of 0x10 returns pad bits 6..2 of port 4 in place with all other bits 0, and a read of 0x11 returns pad bits 5..0 of port 7 with bits 7..6 at 0. Both views ignore the direction bits.
- R7: Writes to 0x10 and 0x11 always reach the data and direction registers of port 8, whatever the remap bit is. With the remap bit clear, reads of those addresses return the normal port 8 data and direction.
- R8: On an open-drain-capable port with its enable bit set, an output pin whose latch is 0 has its output enable high and its output value 0. An output pin whose latch is 1 has its output enable low.
- R9: Open-drain enable bits at 0x2E for ports that cannot use open-drain (by default all but ports 0, 2 and 3) read back as 0 and have no effect on drive.
- R10: A pad change made between clock edges is first seen by a read whose strobe is sampled on the third rising edge after the change. Reads sampled on the first two edges return the old level.
- R11: The read data output holds its value when no read is made. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Registered read data |
| pad_in | input | NUM_PORTS*PORT_W | Pad levels, port k at bits k*PORT_W upward |
| pad_out | output | NUM_PORTS*PORT_W | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |

## Verification
A wrong direction or open-drain bit shows at the output enables on the edge right after the write that set it. A corrupted latch shows on the output values or in a data read one cycle later. A wrong remap decode shows only in the read data for 0x10 and 0x11. For that reason the bench reads those addresses with the remap bit both set and clear, and with the direction bits set against the raw view. A synchronizer that is too short or too long moves the first cycle in which a new pad level can be read, so the bench reads on each of the three edges that follow a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OD_ADDR    = 8'h2E;
  localparam addr_t CTRL_ADDR  = 8'h2F;
  localparam addr_t RAW_A_ADDR = 8'h10;
  localparam addr_t RAW_B_ADDR = 8'h11;

  function automatic addr_t data_addr(input int k);
    return addr_t'(2 * k);
  endfunction

  function automatic addr_t dir_addr(input int k);
    return addr_t'(2 * k + 1);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    stage1_q <= d;
    stage2_q <= stage1_q;
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int   W     = 8,
  parameter logic OD_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         od_we,
  input  logic         od_wbit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] raw_in,
  output logic [W-1:0] dir_val,
  output logic         od_val
);
  logic [W-1:0] latch_q, dir_q, sync_q;
  logic         od_q;

  gpio_sync #(.W(W)) u_sync (.clk(clk), .d(pad_in), .q(sync_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      od_q    <= 1'b0;
    end else begin
      if (data_we) latch_q <= wdata;
      if (dir_we)  dir_q   <= wdata;
      if (od_we)   od_q    <= OD_OK & od_wbit;
    end
  end

  assign pad_out = latch_q;
  assign pad_oe  = od_q ? (dir_q & ~latch_q) : dir_q;
  assign rd_val  = (dir_q & latch_q) | (~dir_q & sync_q);
  assign raw_in  = sync_q;
  assign dir_val = dir_q;
  assign od_val  = od_q;

  // R10: the readable pad level is the pad two edges back
  p_sync_depth_r10: assert property (@(posedge clk) disable iff (rst)
    sync_q == $past(pad_in, 2));

  // R4: a data write leaves input pins undriven
  p_input_write_r4: assert property (@(posedge clk) disable iff (rst)
    (data_we && !dir_we) |=> ((pad_oe & ~$past(dir_q)) == '0));

  // R8: in open-drain mode, a latch written high releases the pin
  p_od_release_r8: assert property (@(posedge clk) disable iff (rst)
    (od_q && data_we && !od_we) |=> ((pad_oe & $past(wdata)) == '0));

  // R9: a port that cannot use open-drain never enters the mode
  p_od_capable_r9: assert property (@(posedge clk) disable iff (rst)
    !OD_OK |-> !od_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int                   NUM_PORTS  = 9,
  parameter int                   PORT_W     = 8,
  parameter logic [NUM_PORTS-1:0] OD_MASK    = 'h00D,
  parameter int                   RAW_A_PORT = 4,
  parameter int                   RAW_A_LO   = 2,
  parameter int                   RAW_A_HI   = 6,
  parameter int                   RAW_B_PORT = 7,
  parameter int                   RAW_B_LO   = 0,
  parameter int                   RAW_B_HI   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe
);
  localparam logic [PORT_W-1:0] MASK_A = PORT_W'(
    ((64'd1 << (RAW_A_HI + 1)) - 64'd1) ^ ((64'd1 << RAW_A_LO) - 64'd1));
  localparam logic [PORT_W-1:0] MASK_B = PORT_W'(
    ((64'd1 << (RAW_B_HI + 1)) - 64'd1) ^ ((64'd1 << RAW_B_LO) - 64'd1));

  logic [PORT_W-1:0] rd_arr  [NUM_PORTS];
  logic [PORT_W-1:0] raw_arr [NUM_PORTS];
  logic [PORT_W-1:0] dir_arr [NUM_PORTS];
  logic [NUM_PORTS-1:0] od_vec;
  logic [PORT_W-1:0] od_word;
  logic              remap_q;
  logic [PORT_W-1:0] rd_mux;
  logic              od_we;

  assign od_we = bus_wr && (bus_addr == OD_ADDR);

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam logic OK = (k < PORT_W) ? OD_MASK[k] : 1'b0;
    logic wbit;
    if (k < PORT_W) begin : g_wbit
      assign wbit = bus_wdata[k];
    end else begin : g_nowbit
      assign wbit = 1'b0;
    end

    gpio_port #(.W(PORT_W), .OD_OK(OK)) u_port (
      .clk     (clk),
      .rst     (rst),
      .data_we (bus_wr && (bus_addr == data_addr(k))),
      .dir_we  (bus_wr && (bus_addr == dir_addr(k))),
      .od_we   (od_we),
      .od_wbit (wbit),
      .wdata   (bus_wdata),
      .pad_in  (pad_in[k*PORT_W +: PORT_W]),
      .pad_out (pad_out[k*PORT_W +: PORT_W]),
      .pad_oe  (pad_oe[k*PORT_W +: PORT_W]),
      .rd_val  (rd_arr[k]),
      .raw_in  (raw_arr[k]),
      .dir_val (dir_arr[k]),
      .od_val  (od_vec[k])
    );
  end

  for (genvar j = 0; j < PORT_W; j++) begin : g_odw
    if (j < NUM_PORTS) begin : g_on
      assign od_word[j] = od_vec[j];
    end else begin : g_off
      assign od_word[j] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) remap_q <= 1'b0;
    else if (bus_wr && (bus_addr == CTRL_ADDR)) remap_q <= bus_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (bus_addr == data_addr(k)) rd_mux = rd_arr[k];
      if (bus_addr == dir_addr(k))  rd_mux = dir_arr[k];
    end
    if (bus_addr == OD_ADDR)   rd_mux = od_word;
    if (bus_addr == CTRL_ADDR) rd_mux = PORT_W'(remap_q);
    if (remap_q && (bus_addr == RAW_A_ADDR)) rd_mux = raw_arr[RAW_A_PORT] & MASK_A;
    if (remap_q && (bus_addr == RAW_B_ADDR)) rd_mux = raw_arr[RAW_B_PORT] & MASK_B;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R11: read data changes only on a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R6: raw views never carry bits outside their fields
  p_raw_a_field_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && remap_q && (bus_addr == RAW_A_ADDR)) |=> ((bus_rdata & ~MASK_A) == '0));
  p_raw_b_field_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && remap_q && (bus_addr == RAW_B_ADDR)) |=> ((bus_rdata & ~MASK_B) == '0));
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [PW-1:0] bus_wdata = '0;
  logic [PW-1:0] bus_rdata;
  logic [NP*PW-1:0] pad_in = '0;
  logic [NP*PW-1:0] pad_out, pad_oe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [PW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [PW-1:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [PW-1:0] oe_of(input int k);
    return pad_oe[k*PW +: PW];
  endfunction
  function automatic logic [PW-1:0] out_of(input int k);
    return pad_out[k*PW +: PW];
  endfunction

  task automatic set_pad(input int k, input logic [PW-1:0] v);
    pad_in[k*PW +: PW] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [PW-1:0] d;
    checks++;
    if (pad_oe !== '0) begin errors++; $display("FAIL R1: oe actual %h expected 0", pad_oe); end
    checks++;
    if (pad_out !== '0) begin errors++; $display("FAIL R1: out actual %h expected 0", pad_out); end
    rd(8'h07, d); chk("R1 dir3", d, 8'h00);
    rd(8'h2E, d); chk("R1 od", d, 8'h00);
    rd(8'h2F, d); chk("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_push_pull;
    wr(8'h04, 8'hA5); wr(8'h05, 8'hFF);
    chk("R2 oe", oe_of(2), 8'hFF);
    chk("R2 out", out_of(2), 8'hA5);
  endtask

  task automatic t_input_write;
    wr(8'h06, 8'h3C);
    chk("R3 oe", oe_of(3), 8'h00);
    chk("R4 oe after data write", oe_of(3), 8'h00);
    wr(8'h07, 8'h0F);
    chk("R4 oe", oe_of(3), 8'h0F);
    chk("R4 out", out_of(3), 8'h3C);
  endtask

  task automatic t_read_mix;
    logic [PW-1:0] d;
    set_pad(3, 8'hA5);
    rd(8'h06, d); chk("R5 mixed", d, 8'hAC);
    set_pad(6, 8'h5A);
    rd(8'h0C, d); chk("R5 all input", d, 8'h5A);
  endtask

  task automatic t_remap;
    logic [PW-1:0] d;
    wr(8'h09, 8'hFF); wr(8'h08, 8'h00);
    set_pad(4, 8'h55); set_pad(7, 8'hAA);
    wr(8'h2F, 8'h01);
    rd(8'h10, d); chk("R6 raw A", d, 8'h54);
    rd(8'h11, d); chk("R6 raw B", d, 8'h2A);
    set_pad(4, 8'hFF);
    rd(8'h10, d); chk("R6 raw A full", d, 8'h7C);
  endtask

  task automatic t_write_through;
    logic [PW-1:0] d;
    set_pad(8, 8'h00);
    wr(8'h10, 8'h99); wr(8'h11, 8'hF0);
    chk("R7 out", out_of(8), 8'h99);
    chk("R7 oe", oe_of(8), 8'hF0);
    wr(8'h2F, 8'h00);
    rd(8'h10, d); chk("R7 data read", d, 8'h90);
    rd(8'h11, d); chk("R7 dir read", d, 8'hF0);
  endtask

  task automatic t_open_drain;
    logic [PW-1:0] d;
    wr(8'h00, 8'h0F); wr(8'h01, 8'hFF);
    wr(8'h02, 8'h0F); wr(8'h03, 8'hFF);
    wr(8'h2E, 8'hFF);
    chk("R8 oe", oe_of(0), 8'hF0);
    chk("R8 out", out_of(0), 8'h0F);
    rd(8'h2E, d); chk("R9 od readback", d, 8'h0D);
    chk("R9 port1 oe", oe_of(1), 8'hFF);
    wr(8'h2E, 8'h00);
    chk("R8 off", oe_of(0), 8'hFF);
  endtask

  task automatic t_sync;
    logic [PW-1:0] d;
    pad_in[5*PW +: PW] = 8'h00;
    repeat (3) @(negedge clk);
    pad_in[5*PW +: PW] = 8'hC3;
    rd(8'h0A, d); chk("R10 edge1", d, 8'h00);
    rd(8'h0A, d); chk("R10 edge2", d, 8'h00);
    rd(8'h0A, d); chk("R10 edge3", d, 8'hC3);
  endtask

  task automatic t_bus;
    logic [PW-1:0] d;
    rd(8'h20, d); chk("R11 unmapped", d, 8'h00);
    rd(8'h04, d);
    repeat (4) @(negedge clk);
    chk("R11 hold", bus_rdata, 8'hA5);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_push_pull;
    t_input_write;
    t_read_mix;
    t_remap;
    t_write_through;
    t_open_drain;
    t_sync;
    t_bus;
    finish_up;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end
endmodule